// File: doc/BRIEF.md
# Overlapped Fetch Hazard Controller

This block steers a two-stage processor whose instructions and data share one memory port. While the instruction held in the instruction register (IR) executes, the next instruction word is fetched from the address in the program counter (PC). The block holds the PC and IR registers and drives the memory address multiplexer. A decoder outside the block sends a set of class flags for the IR contents and a branch outcome. From these the block decides, each cycle, whether the memory serves the fetch or a data access, and whether the PC advances, holds or loads a branch target. When a fetch cannot be used, the block writes the all-zero word (a nop) into the IR.

A small phase machine sequences the work. Reset enters `ST_FILL`: the IR holds the reset nop and the first fetch is made. `ST_FILL` always moves to `ST_FLOW`. In `ST_FLOW` the IR holds a real instruction. If that instruction needs the memory or changes control flow, the block raises `stall` and moves to `ST_BUBBLE`; otherwise it stays in `ST_FLOW`. `ST_BUBBLE` means the IR holds an injected nop. It ignores the class flags, fetches normally and always returns to `ST_FLOW`. Three counters record cycles, executed instructions and stalls. Cycles per instruction therefore come out to one plus the stall fraction.

Top module: `ovl_fetch_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, the PC equals the `RESET_VEC` parameter, the IR is 0, all three counters are 0, `stall` is 0 and `mem_addr` equals the PC.
- R2: In `ST_FLOW` with no class flag that causes a hazard, `stall`=0, `pc_en`=1, `pc_src`=0, `ir_src`=0 and `addr_sel`=0. `mem_addr` equals the PC. At the next edge the IR takes `mem_rdata` and the PC grows by `PC_STEP` (4).
- R3: In `ST_FLOW` with `ir_kind` bit 0 (load) or bit 1 (store) set and no redirect, `stall`=1, `pc_en`=0, `ir_src`=1 and `addr_sel`=1. `mem_addr` equals `alu_addr`. At the next edge the PC keeps its value and the IR becomes 0.
- R4: In `ST_FLOW` with `ir_kind` bit 2 (jump) set, or bit 3 (branch) set together with `br_taken`, `stall`=1, `pc_en`=1, `pc_src`=1 and `ir_src`=1. At the next edge the PC takes `br_target` and the IR becomes 0.
- R5: A branch with `br_taken`=0 and no other flag causes no stall and flows as in R2.
- R6: When a redirect and a load or store are flagged together, the PC loads `br_target` (redirect wins), `addr_sel`=1 still gives the data access the memory, and a single nop is injected.
- R7: The cycle after any stall is `ST_BUBBLE`. In that cycle the class flags and `br_taken` are ignored: `stall`=0, `pc_en`=1, `addr_sel`=0, the PC advances and the IR loads `mem_rdata`. As a result, each stalling instruction raises `stall` for exactly one cycle.
- R8: `cycle_cnt` counts every cycle after `ST_FILL`, `instr_cnt` counts `ST_FLOW` cycles and `stall_cnt` counts cycles with `stall`=1. Outside `ST_BUBBLE`, `cycle_cnt` = `instr_cnt` + `stall_cnt`, so CPI = 1 + f.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_kind | input | 4 | Class flags of the IR contents: bit0 load, bit1 store, bit2 jump, bit3 branch |
| br_taken | input | 1 | Branch outcome for the IR instruction |
| mem_rdata | input | IW | Word read from the shared memory |
| alu_addr | input | AW | Data address computed by the ALU |
| br_target | input | AW | Jump or branch target |
| mem_addr | output | AW | Address sent to the shared memory |
| pc | output | AW | Program counter |
| ir | output | IW | Instruction register |
| pc_en | output | 1 | PC write enable |
| pc_src | output | 1 | PC source: 0 = PC + step, 1 = target |
| ir_src | output | 1 | IR source: 0 = memory, 1 = nop |
| addr_sel | output | 1 | Memory address select: 0 = PC, 1 = ALU |
| stall | output | 1 | The IR instruction stalls fetch this cycle |
| cycle_cnt | output | CW | Cycles since the fill cycle |
| instr_cnt | output | CW | Instructions executed |
| stall_cnt | output | CW | Stall cycles |

## Verification
If the phase machine held a wrong phase, the error would show in the same cycle. A missed bubble makes `stall` stay high for a second cycle or lets the nop's flags act. A phantom bubble drops a hazard, so `addr_sel` stays at 0 while a load is flagged. One cycle later the error reaches `pc` and `ir`: a lost hold skips an instruction address and a missed nop leaves a fetched word in the IR. The counters lose their balance at the next non-bubble cycle. The bench compares every output on every cycle against its own model, so any of these faults is reported within one or two cycles.

// File: rtl/ovl_fetch_pkg.sv
package ovl_fetch_pkg;
    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_FLOW   = 2'd1,
        ST_BUBBLE = 2'd2
    } phase_e;

    localparam int KIND_W   = 4;
    localparam int K_LOAD   = 0;
    localparam int K_STORE  = 1;
    localparam int K_JUMP   = 2;
    localparam int K_BRANCH = 3;

    localparam int N_CNT   = 3;
    localparam int CNT_CYC = 0;
    localparam int CNT_INS = 1;
    localparam int CNT_STL = 2;
endpackage

// File: rtl/ovl_phase_fsm.sv
module ovl_phase_fsm
    import ovl_fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KIND_W-1:0] ir_kind,
    input  logic              br_taken,
    output phase_e            phase,
    output logic              stall,
    output logic              pc_en,
    output logic              pc_src,
    output logic              ir_src,
    output logic              addr_sel
);
    phase_e phase_q, phase_d;
    logic   mem_op, redirect;

    assign mem_op   = ir_kind[K_LOAD] | ir_kind[K_STORE];
    assign redirect = ir_kind[K_JUMP] | (ir_kind[K_BRANCH] & br_taken);
    assign phase    = phase_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= ST_FILL;
        else        phase_q <= phase_d;
    end

    // transitions
    always_comb begin
        phase_d = ST_FLOW;
        unique case (phase_q)
            ST_FILL:   phase_d = ST_FLOW;
            ST_FLOW:   phase_d = (mem_op | redirect) ? ST_BUBBLE : ST_FLOW;
            ST_BUBBLE: phase_d = ST_FLOW;
            default:   phase_d = ST_FLOW;
        endcase
    end

    // outputs
    always_comb begin
        stall    = 1'b0;
        pc_en    = 1'b1;
        pc_src   = 1'b0;
        ir_src   = 1'b0;
        addr_sel = 1'b0;
        unique case (phase_q)
            ST_FLOW: begin
                stall    = mem_op | redirect;
                pc_en    = redirect | ~mem_op;
                pc_src   = redirect;
                ir_src   = mem_op | redirect;
                addr_sel = mem_op;
            end
            ST_FILL, ST_BUBBLE: begin
                stall = 1'b0;
            end
            default: begin
                stall = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ovl_fetch_regs.sv
module ovl_fetch_regs #(
    parameter int             AW        = 32,
    parameter int             IW        = 32,
    parameter int             PC_STEP   = 4,
    parameter logic [AW-1:0]  RESET_VEC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pc_en,
    input  logic          pc_src,
    input  logic          ir_src,
    input  logic          addr_sel,
    input  logic [IW-1:0] mem_rdata,
    input  logic [AW-1:0] alu_addr,
    input  logic [AW-1:0] br_target,
    output logic [AW-1:0] pc,
    output logic [IW-1:0] ir,
    output logic [AW-1:0] mem_addr
);
    localparam logic [AW-1:0] STEP = AW'(PC_STEP);
    localparam logic [IW-1:0] NOP  = '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_VEC;
            ir <= NOP;
        end else begin
            if (pc_en) pc <= pc_src ? br_target : pc + STEP;
            ir <= ir_src ? NOP : mem_rdata;
        end
    end

    assign mem_addr = addr_sel ? alu_addr : pc;
endmodule

// File: rtl/ovl_perf_counters.sv
module ovl_perf_counters #(
    parameter int CW = 32,
    parameter int N  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         inc,
    output logic [N-1:0][CW-1:0] count
);
    for (genvar g = 0; g < N; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)      count[g] <= '0;
            else if (inc[g]) count[g] <= count[g] + CW'(1);
        end
    end
endmodule

// File: rtl/ovl_fetch_ctl.sv
module ovl_fetch_ctl
    import ovl_fetch_pkg::*;
#(
    parameter int            AW        = 32,
    parameter int            IW        = 32,
    parameter int            CW        = 32,
    parameter int            PC_STEP   = 4,
    parameter logic [AW-1:0] RESET_VEC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    ir_kind,
    input  logic          br_taken,
    input  logic [IW-1:0] mem_rdata,
    input  logic [AW-1:0] alu_addr,
    input  logic [AW-1:0] br_target,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] pc,
    output logic [IW-1:0] ir,
    output logic          pc_en,
    output logic          pc_src,
    output logic          ir_src,
    output logic          addr_sel,
    output logic          stall,
    output logic [CW-1:0] cycle_cnt,
    output logic [CW-1:0] instr_cnt,
    output logic [CW-1:0] stall_cnt
);
    phase_e                  cur_phase;
    logic [N_CNT-1:0]        cnt_inc;
    logic [N_CNT-1:0][CW-1:0] cnt_val;

    ovl_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ir_kind  (ir_kind),
        .br_taken (br_taken),
        .phase    (cur_phase),
        .stall    (stall),
        .pc_en    (pc_en),
        .pc_src   (pc_src),
        .ir_src   (ir_src),
        .addr_sel (addr_sel)
    );

    ovl_fetch_regs #(
        .AW(AW), .IW(IW), .PC_STEP(PC_STEP), .RESET_VEC(RESET_VEC)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pc_en     (pc_en),
        .pc_src    (pc_src),
        .ir_src    (ir_src),
        .addr_sel  (addr_sel),
        .mem_rdata (mem_rdata),
        .alu_addr  (alu_addr),
        .br_target (br_target),
        .pc        (pc),
        .ir        (ir),
        .mem_addr  (mem_addr)
    );

    assign cnt_inc[CNT_CYC] = (cur_phase != ST_FILL);
    assign cnt_inc[CNT_INS] = (cur_phase == ST_FLOW);
    assign cnt_inc[CNT_STL] = stall;

    ovl_perf_counters #(.CW(CW), .N(N_CNT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .count (cnt_val)
    );

    assign cycle_cnt = cnt_val[CNT_CYC];
    assign instr_cnt = cnt_val[CNT_INS];
    assign stall_cnt = cnt_val[CNT_STL];
endmodule

// File: rtl/ovl_fetch_chk.sv
module ovl_fetch_chk
    import ovl_fetch_pkg::*;
#(
    parameter int AW      = 32,
    parameter int IW      = 32,
    parameter int CW      = 32,
    parameter int PC_STEP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input phase_e        phase,
    input logic [AW-1:0] pc,
    input logic [IW-1:0] ir,
    input logic [AW-1:0] br_target,
    input logic          pc_en,
    input logic          pc_src,
    input logic          addr_sel,
    input logic          stall,
    input logic [CW-1:0] cycle_cnt,
    input logic [CW-1:0] instr_cnt,
    input logic [CW-1:0] stall_cnt
);
    AST_STALL_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (ir == '0)); // R3
    AST_HOLD_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !pc_en) |=> $stable(pc)); // R3
    AST_REDIRECT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_en && pc_src) |=> (pc == $past(br_target))); // R4
    AST_FLOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (pc == AW'($past(pc) + AW'(PC_STEP)))); // R2
    AST_ONE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall); // R7
    AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_BUBBLE) |-> (!stall && pc_en && !addr_sel)); // R7
    AST_DATA_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        addr_sel |-> (stall && (!pc_en || pc_src))); // R6
    AST_CPI_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != ST_BUBBLE) |-> (cycle_cnt == CW'(instr_cnt + stall_cnt))); // R8
endmodule

bind ovl_fetch_ctl ovl_fetch_chk #(
    .AW(AW), .IW(IW), .CW(CW), .PC_STEP(PC_STEP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (cur_phase),
    .pc        (pc),
    .ir        (ir),
    .br_target (br_target),
    .pc_en     (pc_en),
    .pc_src    (pc_src),
    .addr_sel  (addr_sel),
    .stall     (stall),
    .cycle_cnt (cycle_cnt),
    .instr_cnt (instr_cnt),
    .stall_cnt (stall_cnt)
);

// File: tb/ovl_fetch_ctl_test.sv
module ovl_fetch_ctl_test;
    localparam logic [31:0] RVEC = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  ir_kind;
    logic        br_taken;
    logic [31:0] mem_rdata, alu_addr, br_target;
    logic [31:0] mem_addr, pc, ir;
    logic        pc_en, pc_src, ir_src, addr_sel, stall;
    logic [31:0] cycle_cnt, instr_cnt, stall_cnt;

    int n_cmp = 0;
    int n_bad = 0;

    // model state: 0 fill, 1 flow, 2 bubble
    int          m_ph;
    logic [31:0] m_pc, m_ir, m_cyc, m_ins, m_stl;

    always #10 clk = ~clk;

    ovl_fetch_ctl #(.RESET_VEC(RVEC)) uut (
        .clk(clk), .rst_n(rst_n), .ir_kind(ir_kind), .br_taken(br_taken),
        .mem_rdata(mem_rdata), .alu_addr(alu_addr), .br_target(br_target),
        .mem_addr(mem_addr), .pc(pc), .ir(ir), .pc_en(pc_en), .pc_src(pc_src),
        .ir_src(ir_src), .addr_sel(addr_sel), .stall(stall),
        .cycle_cnt(cycle_cnt), .instr_cnt(instr_cnt), .stall_cnt(stall_cnt)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_pc = RVEC; m_ir = '0;
        m_cyc = '0; m_ins = '0; m_stl = '0;
    endtask

    task automatic check_regs(string req);
        chk(req, "pc", pc, m_pc);
        chk(req, "ir", ir, m_ir);
        chk("R8", "cycle_cnt", cycle_cnt, m_cyc);
        chk("R8", "instr_cnt", instr_cnt, m_ins);
        chk("R8", "stall_cnt", stall_cnt, m_stl);
    endtask

    // called at a negedge; leaves at the next negedge
    task automatic step(logic [3:0] k, logic tk, logic [31:0] rd, logic [31:0] alu, logic [31:0] tg);
        logic  act, mem_op, redir, e_stall, e_pcen;
        string req;
        ir_kind = k; br_taken = tk; mem_rdata = rd; alu_addr = alu; br_target = tg;
        #1;
        act    = (m_ph == 1);
        mem_op = act && (k[0] || k[1]);
        redir  = act && (k[2] || (k[3] && tk));
        e_stall = mem_op || redir;
        e_pcen  = redir || !mem_op;
        if (m_ph == 0)            req = "R1";
        else if (m_ph == 2)       req = "R7";
        else if (mem_op && redir) req = "R6";
        else if (redir)           req = "R4";
        else if (mem_op)          req = "R3";
        else if (k[3])            req = "R5";
        else                      req = "R2";
        chk(req, "stall", stall, e_stall);
        chk(req, "pc_en", pc_en, e_pcen);
        chk(req, "pc_src", pc_src, redir);
        chk(req, "ir_src", ir_src, e_stall);
        chk(req, "addr_sel", addr_sel, mem_op);
        chk(req, "mem_addr", mem_addr, mem_op ? alu : m_pc);
        if (m_ph != 0) m_cyc = m_cyc + 1;
        if (m_ph == 1) m_ins = m_ins + 1;
        if (e_stall)   m_stl = m_stl + 1;
        if (redir)        m_pc = tg;
        else if (!mem_op) m_pc = m_pc + 32'd4;
        m_ir = e_stall ? 32'h0 : rd;
        m_ph = e_stall ? 2 : 1;
        @(negedge clk);
        check_regs(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ir_kind = '0; br_taken = 1'b0; mem_rdata = 32'hdead_beef;
        alu_addr = '0; br_target = '0;
        @(negedge clk); @(negedge clk);
        model_reset();
        check_regs("R1");
        chk("R1", "stall in reset", stall, 1'b0);
        rst_n = 1'b1;
        #1;
        chk("R1", "mem_addr after reset", mem_addr, RVEC);
        chk("R1", "stall after reset", stall, 1'b0);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        // fill, then plain flow (R2)
        step(4'b0000, 1'b0, 32'h1111_0001, 32'h0, 32'h0);
        step(4'b0000, 1'b0, 32'h1111_0002, 32'h0, 32'h0);
        // load: hold (R3), then bubble with flags that would stall (R7 ignored)
        step(4'b0001, 1'b0, 32'h2222_0001, 32'h0000_8000, 32'h0);
        step(4'b1111, 1'b1, 32'h2222_0002, 32'h0000_8004, 32'h0000_4444);
        // store back to back with a load (R3)
        step(4'b0010, 1'b0, 32'h3333_0001, 32'h0000_9000, 32'h0);
        step(4'b0000, 1'b0, 32'h3333_0002, 32'h0, 32'h0);
        step(4'b0001, 1'b0, 32'h3333_0003, 32'h0000_9100, 32'h0);
        step(4'b0000, 1'b0, 32'h3333_0004, 32'h0, 32'h0);
        // jump (R4)
        step(4'b0100, 1'b0, 32'h4444_0001, 32'h0, 32'h0000_2000);
        step(4'b0000, 1'b0, 32'h4444_0002, 32'h0, 32'h0);
        // branch taken (R4) and not taken (R5)
        step(4'b1000, 1'b1, 32'h5555_0001, 32'h0, 32'h0000_3000);
        step(4'b0000, 1'b0, 32'h5555_0002, 32'h0, 32'h0);
        step(4'b1000, 1'b0, 32'h5555_0003, 32'h0, 32'h0000_3800);
        // redirect together with load (R6)
        step(4'b0101, 1'b0, 32'h6666_0001, 32'h0000_a000, 32'h0000_5000);
        step(4'b0000, 1'b0, 32'h6666_0002, 32'h0, 32'h0);
        step(4'b1010, 1'b1, 32'h6666_0003, 32'h0000_a100, 32'h0000_5800);
        step(4'b0000, 1'b0, 32'h6666_0004, 32'h0, 32'h0);
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] k;
            k = ($urandom % 10 < 5) ? 4'b0000 : 4'($urandom);
            step(k, 1'($urandom), $urandom | 32'h1, $urandom, $urandom & 32'hffff_fffc);
        end
        // reset again mid-stream (R1)
        do_reset();
        step(4'b0001, 1'b0, 32'h7777_0001, 32'h0000_b000, 32'h0);
        step(4'b0001, 1'b0, 32'h7777_0002, 32'h0000_b004, 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule